// File: doc/BRIEF.md
# I2C Event Flag and Interrupt Vector Unit

This block gathers the single-cycle event pulses produced by an I2C controller core: arbitration lost, NACK received, access ready, receive ready, transmit ready, stop seen, and addressed as a target. It latches each pulse into a sticky flag. A mask register selects which flags may raise the single interrupt line.

Software services the unit through a small register port. It can read the raw flags and two live bus indications from the status register. It can clear flags by writing ones. It can also read a vector register repeatedly. Each vector read reports the highest-priority pending enabled event as a 3-bit code and retires that event, until the vector reads zero.

The two data-ready flags are the exception to that retirement rule. They stay set across vector reads and are cleared only by access to the data locations.

Top module: `i2cv_top`

## Requirements
- R1: After reset every event flag, the mask register and `irq` are 0, and the vector register reads 0.
- R2: A pulse on an event input sets its flag on the next clock edge. The flag is visible in the status register (address 1) whatever the mask. Status bit positions: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as target. No flag sets without its event.
- R3: Status bit 11 shows the `rx_shift_full` input and status bit 12 shows the `bus_busy` input, in the same cycle and with no latching.
- R4: The mask register sits at address 0. It is written and read back on bits 6:0, with the same bit order as the status flags.
- R5: A read of the vector register (address 2) returns the code of the lowest-numbered pending enabled event, or 0 if none is pending. The codes are: arbitration lost 1, NACK 2, access ready 3, receive ready 4, transmit ready 5, stop seen 6, addressed as target 7.
- R6: A vector read retires the flag whose code it returned. The exception is codes 4 and 5: those flags remain set after the read.
- R7: Writing the status register clears each of the flags at bits 0, 1, 2, 5 and 6 whose write-data bit is 1. Zero bits have no effect. Bits 3 and 4 ignore the write.
- R8: A read of the receive data location (address 3) clears the receive-ready flag. A write of the transmit data location (address 4) clears the transmit-ready flag.
- R9: `irq` is a register. One cycle after the flags and mask change, it equals the OR of (flags AND mask).
- R10: When an event pulse and any clear of the same flag happen in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from current state |
| ev_arb_lost | input | 1 | Arbitration-lost pulse |
| ev_nack | input | 1 | NACK-received pulse |
| ev_acc_rdy | input | 1 | Access-ready pulse |
| ev_rx_rdy | input | 1 | Receive-ready pulse |
| ev_tx_rdy | input | 1 | Transmit-ready pulse |
| ev_stop | input | 1 | Stop-seen pulse |
| ev_tgt_addr | input | 1 | Addressed-as-target pulse |
| rx_shift_full | input | 1 | Live receive-shifter-full level |
| bus_busy | input | 1 | Live bus-busy level |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high together, and that the event inputs are one-cycle pulses on separate edges from the register strobes, except where the bench deliberately overlaps an event with a clear. The stimulus drives every input at the falling clock edge and deasserts each strobe after one cycle. The event-versus-clear test is the only case that raises an event in the same cycle as a status write or a vector read.

// File: rtl/i2cv_pkg.sv
package i2cv_pkg;
  localparam int NEV    = 7;
  localparam int CODE_W = 3;
  localparam int RX_BIT = 3;
  localparam int TX_BIT = 4;
  localparam int STAT_RXFULL = 11;
  localparam int STAT_BUSY   = 12;

  typedef enum logic [2:0] {
    A_MASK = 3'd0,
    A_STAT = 3'd1,
    A_VEC  = 3'd2,
    A_RXD  = 3'd3,
    A_TXD  = 3'd4
  } reg_addr_e;

  // flags that a status write or a vector read may retire
  localparam logic [NEV-1:0] SW_CLEARABLE = 7'b1100111;

  // code of lowest set request, 0 if none
  function automatic logic [CODE_W-1:0] first_code(input logic [NEV-1:0] req);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NEV - 1; i >= 0; i--)
      if (req[i]) c = CODE_W'(i + 1);
    return c;
  endfunction

  // one-hot flag selected by a nonzero code
  function automatic logic [NEV-1:0] code_to_bit(input logic [CODE_W-1:0] c);
    logic [NEV-1:0] b;
    b = '0;
    if (c != '0) b[c - 1'b1] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/i2cv_flag_bank.sv
module i2cv_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cv_prio_enc.sv
module i2cv_prio_enc
  import i2cv_pkg::*;
(
  input  logic [NEV-1:0]    req_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb code_o = first_code(req_i);
endmodule

// File: rtl/i2cv_top.sv
module i2cv_top
  import i2cv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_arb_lost,
  input  logic              ev_nack,
  input  logic              ev_acc_rdy,
  input  logic              ev_rx_rdy,
  input  logic              ev_tx_rdy,
  input  logic              ev_stop,
  input  logic              ev_tgt_addr,
  input  logic              rx_shift_full,
  input  logic              bus_busy,
  output logic              irq
);
  logic [NEV-1:0]    ev_vec, clr_vec, pend_q, mask_q, live;
  logic [CODE_W-1:0] vec_code;
  logic              wr_mask, wr_stat, vec_rd, rx_acc, tx_acc;

  assign ev_vec = {ev_tgt_addr, ev_stop, ev_tx_rdy, ev_rx_rdy,
                   ev_acc_rdy, ev_nack, ev_arb_lost};

  assign wr_mask = reg_wr && (reg_addr == ADDR_W'(A_MASK));
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));
  assign vec_rd  = reg_rd && (reg_addr == ADDR_W'(A_VEC));
  assign rx_acc  = reg_rd && (reg_addr == ADDR_W'(A_RXD));
  assign tx_acc  = reg_wr && (reg_addr == ADDR_W'(A_TXD));

  assign live = pend_q & mask_q;

  i2cv_prio_enc u_enc (
    .req_i  (live),
    .code_o (vec_code)
  );

  always_comb begin
    clr_vec = '0;
    if (wr_stat) clr_vec |= reg_wdata[NEV-1:0] & SW_CLEARABLE;
    if (vec_rd)  clr_vec |= code_to_bit(vec_code) & SW_CLEARABLE;
    clr_vec[RX_BIT] = rx_acc;
    clr_vec[TX_BIT] = tx_acc;
  end

  i2cv_flag_bank #(.N(NEV)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ev_vec),
    .clr_i  (clr_vec),
    .flag_o (pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[NEV-1:0];
      irq <= |live;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_MASK): reg_rdata[NEV-1:0] = mask_q;
      ADDR_W'(A_STAT): begin
        reg_rdata[NEV-1:0]   = pend_q;
        reg_rdata[STAT_RXFULL] = rx_shift_full;
        reg_rdata[STAT_BUSY]   = bus_busy;
      end
      ADDR_W'(A_VEC):  reg_rdata[CODE_W-1:0] = vec_code;
      default:         reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cv_chk.sv
module i2cv_chk
  import i2cv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NEV-1:0]    ev,
  input logic [NEV-1:0]    pend,
  input logic [NEV-1:0]    mask,
  input logic [CODE_W-1:0] code,
  input logic              vec_rd,
  input logic              rx_acc,
  input logic              irq
);
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(pend) & $past(mask)))); // R9

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((pend & $past(ev)) == $past(ev))); // R10

  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(ev)) == '0)); // R2

  AST_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> ((pend & mask) == '0)); // R5

  AST_VEC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> (((pend & mask) >> (code - 1'b1)) & 7'd1) != '0); // R5

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && code == 3'd4 && !rx_acc) |=> pend[RX_BIT]); // R6
endmodule

bind i2cv_top i2cv_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ev     (ev_vec),
  .pend   (pend_q),
  .mask   (mask_q),
  .code   (vec_code),
  .vec_rd (vec_rd),
  .rx_acc (rx_acc),
  .irq    (irq)
);

// File: tb/i2cv_top_tb.sv
module i2cv_top_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [6:0]  ev = 0;
  logic        rx_shift_full = 0, bus_busy = 0, irq;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  i2cv_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]),
    .ev_rx_rdy(ev[3]), .ev_tx_rdy(ev[4]), .ev_stop(ev[5]),
    .ev_tgt_addr(ev[6]), .rx_shift_full(rx_shift_full),
    .bus_busy(bus_busy), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic pulse(input logic [6:0] e);
    ev = e;
    @(negedge clk);
    ev = 0;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    wr(3'd1, 16'h007F);
    rd(3'd3, d);
    wr(3'd4, 16'h0000);
  endtask

  // {events, mask, expected code, expected irq}
  localparam logic [17:0] TBL [9] = '{
    {7'b0000001, 7'b1111111, 3'd1, 1'b1},
    {7'b1111111, 7'b1111111, 3'd1, 1'b1},
    {7'b1111110, 7'b1111111, 3'd2, 1'b1},
    {7'b1111111, 7'b1111100, 3'd3, 1'b1},
    {7'b1100000, 7'b1111111, 3'd6, 1'b1},
    {7'b1000000, 7'b1000000, 3'd7, 1'b1},
    {7'b0011000, 7'b0010000, 3'd5, 1'b1},
    {7'b0000101, 7'b0000000, 3'd0, 1'b0},
    {7'b0000000, 7'b1111111, 3'd0, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(3'd1, d); check("R1 status", d, 16'h0000);
    rd(3'd0, d); check("R1 mask", d, 16'h0000);
    rd(3'd2, d); check("R1 vector", d, 16'h0000);

    // R4 mask readback
    wr(3'd0, 16'hFF55); rd(3'd0, d); check("R4 mask", d, 16'h0055);

    // R5 R9 table walk
    foreach (TBL[i]) begin
      clear_all();
      wr(3'd0, {9'd0, TBL[i][10:4]});
      pulse(TBL[i][17:11]);
      @(negedge clk);
      check("R9 irq", {15'd0, irq}, {15'd0, TBL[i][0]});
      rd(3'd2, d);
      check("R5 code", d, {13'd0, TBL[i][3:1]});
    end

    // R3 live bus levels
    clear_all();
    bus_busy = 1; rx_shift_full = 0;
    rd(3'd1, d); check("R3 busy", d, 16'h1000);
    bus_busy = 0; rx_shift_full = 1;
    rd(3'd1, d); check("R3 rxfull", d, 16'h0800);
    rx_shift_full = 0;

    // R2 masked flags still visible in status
    wr(3'd0, 16'h0000);
    pulse(7'b0000010);
    rd(3'd1, d); check("R2 masked nack", d, 16'h0002);
    rd(3'd2, d); check("R2 masked vector", d, 16'h0000);

    // R7 write-one-clear
    clear_all();
    pulse(7'b0100001);
    wr(3'd1, 16'h0000); rd(3'd1, d); check("R7 zero write", d, 16'h0021);
    wr(3'd1, 16'h0001); rd(3'd1, d); check("R7 clear bit0", d, 16'h0020);
    pulse(7'b0011000);
    wr(3'd1, 16'h0018); rd(3'd1, d); check("R7 rdy ignore", d, 16'h0038);

    // R8 data access clears ready flags
    rd(3'd3, d); rd(3'd1, d); check("R8 rx clear", d, 16'h0030);
    wr(3'd4, 16'h00A5); rd(3'd1, d); check("R8 tx clear", d, 16'h0020);

    // R6 vector drain
    clear_all();
    wr(3'd0, 16'h007F);
    pulse(7'b1100111);
    rd(3'd2, d); check("R6 drain 1", d, 16'd1);
    rd(3'd2, d); check("R6 drain 2", d, 16'd2);
    rd(3'd2, d); check("R6 drain 3", d, 16'd3);
    rd(3'd2, d); check("R6 drain 6", d, 16'd6);
    rd(3'd2, d); check("R6 drain 7", d, 16'd7);
    rd(3'd2, d); check("R6 drain 0", d, 16'd0);
    @(negedge clk);
    check("R9 irq idle", {15'd0, irq}, 16'd0);

    // R6 receive ready survives vector reads
    pulse(7'b0001000);
    rd(3'd2, d); check("R6 rx first", d, 16'd4);
    rd(3'd2, d); check("R6 rx again", d, 16'd4);
    rd(3'd3, d); rd(3'd2, d); check("R8 rx gone", d, 16'd0);

    // R10 event versus status write
    clear_all();
    ev = 7'b0000001; reg_wr = 1; reg_addr = 3'd1; reg_wdata = 16'h0001;
    @(negedge clk);
    ev = 0; reg_wr = 0;
    rd(3'd1, d); check("R10 vs write", d, 16'h0001);

    // R10 event versus vector read
    rd(3'd2, d); rd(3'd2, d);
    pulse(7'b0000001);
    ev = 7'b0000001; reg_rd = 1; reg_addr = 3'd2;
    #1 d = reg_rdata;
    check("R10 vec code", d, 16'd1);
    @(negedge clk);
    ev = 0; reg_rd = 0;
    rd(3'd1, d); check("R10 vs vec read", d, 16'h0001);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule